// File: doc/BRIEF.md
# Shift, Rotate and Nibble Swap Unit

This block is the single-bit shift path of a small processor datapath. It takes one operand, the current carry flag and a 3-bit operation code. It returns the moved operand together with new Z, C, N, V and S flag values. Each flag has its own write strobe, so the status register outside the block knows which bits to update. The data path and the flag logic are combinational. A register stage at the top turns the unit into a one-cycle pipeline step.

The operations are:
- logical shift left and logical shift right;
- arithmetic shift right, which keeps the sign bit;
- rotate left and rotate right through the incoming carry;
- nibble swap.

The swap changes the operand but writes no flag. The two unused operation codes pass the operand through unchanged and also write no flag.

Top module: `shrot_unit`

## Requirements
- R1: While rst_ni is low, result_o, every flag value output and every flag write strobe are 0.
- R2: Operation code 0 (shift left) returns the operand moved up one place with a 0 in bit 0. C is the old most significant bit.
- R3: Operation code 1 (logical shift right) returns the operand moved down one place with a 0 in the top bit. C is the old bit 0.
- R4: Operation code 2 (rotate left) moves the operand up one place and puts carry_i into bit 0. C is the old top bit.
- R5: Operation code 3 (rotate right) moves the operand down one place and puts carry_i into the top bit. C is the old bit 0.
- R6: Operation code 4 (arithmetic shift right) moves the operand down one place and keeps the top bit unchanged. C is the old bit 0.
- R7: Operation code 5 (swap) exchanges the upper and lower halves of the operand. All five write strobes are 0, and all five flag value outputs are 0.
- R8: For codes 0 to 4, all five write strobes are 1, and the flags follow these rules:
  - N is the top bit of the result;
  - Z is 1 exactly when the result is zero;
  - V is N XOR C;
  - S is N XOR V.
- R9: The outputs after a rising clock edge reflect the inputs sampled at that edge. This is a latency of one cycle, and a new operation can be accepted on every cycle.
- R10: Operation codes 6 and 7 return the operand unchanged. All write strobes and all flag value outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (0 to 7) |
| operand_i | input | WIDTH | Operand to move |
| carry_i | input | 1 | Current carry flag |
| result_o | output | WIDTH | Registered result |
| z_o | output | 1 | Zero flag value |
| c_o | output | 1 | Carry flag value |
| n_o | output | 1 | Negative flag value |
| v_o | output | 1 | Overflow flag value |
| s_o | output | 1 | Sign flag value |
| z_we_o | output | 1 | Z write strobe |
| c_we_o | output | 1 | C write strobe |
| n_we_o | output | 1 | N write strobe |
| v_we_o | output | 1 | V write strobe |
| s_we_o | output | 1 | S write strobe |

## Verification
The carry moving through a rotate and the zero detection on the result can meet in the same cycle. The bench provokes this by rotating 0x80 left with a carry of 0: the only set bit leaves into C while bit 0 is filled with the carry, so the result is zero. The same meeting happens when 0x01 is rotated right with a carry of 0. In both cases the bench judges that Z=1, C=1, N=0 and V=1 appear together in the one output cycle. Back-to-back operations with different codes confirm that flags from one cycle do not leak into the next.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_ROTL = 3'd2,
    OP_ROTR = 3'd3,
    OP_SAR  = 3'd4,
    OP_SWAP = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } shrot_op_e;

  typedef struct packed {
    logic z;
    logic c;
    logic n;
    logic v;
    logic s;
  } shrot_flags_t;
endpackage

// File: rtl/shrot_datapath.sv
module shrot_datapath
  import shrot_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  shrot_op_e        op_i,
  input  logic [WIDTH-1:0] operand_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             flag_op_o
);
  localparam int unsigned HALF = WIDTH / 2;

  logic [WIDTH-1:0] swapped;

  // swap halves
  for (genvar i = 0; i < HALF; i++) begin : g_swap
    assign swapped[i]      = operand_i[i+HALF];
    assign swapped[i+HALF] = operand_i[i];
  end

  always_comb begin
    result_o  = operand_i;
    carry_o   = 1'b0;
    flag_op_o = 1'b1;
    unique case (op_i)
      OP_SHL: begin
        result_o = {operand_i[WIDTH-2:0], 1'b0};
        carry_o  = operand_i[WIDTH-1];
      end
      OP_SHR: begin
        result_o = {1'b0, operand_i[WIDTH-1:1]};
        carry_o  = operand_i[0];
      end
      OP_ROTL: begin
        result_o = {operand_i[WIDTH-2:0], carry_i};
        carry_o  = operand_i[WIDTH-1];
      end
      OP_ROTR: begin
        result_o = {carry_i, operand_i[WIDTH-1:1]};
        carry_o  = operand_i[0];
      end
      OP_SAR: begin
        result_o = {operand_i[WIDTH-1], operand_i[WIDTH-1:1]};
        carry_o  = operand_i[0];
      end
      OP_SWAP: begin
        result_o  = swapped;
        flag_op_o = 1'b0;
      end
      default: flag_op_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/shrot_flag_gen.sv
module shrot_flag_gen
  import shrot_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] result_i,
  input  logic             carry_i,
  input  logic             flag_op_i,
  output shrot_flags_t     flags_o,
  output shrot_flags_t     we_o
);
  logic neg, ovf;

  assign neg = result_i[WIDTH-1];
  assign ovf = neg ^ carry_i;

  always_comb begin
    flags_o = '0;
    we_o    = '0;
    if (flag_op_i) begin
      flags_o.z = (result_i == '0);
      flags_o.c = carry_i;
      flags_o.n = neg;
      flags_o.v = ovf;
      flags_o.s = neg ^ ovf;
      we_o      = '1;
    end
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] operand_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             z_o,
  output logic             c_o,
  output logic             n_o,
  output logic             v_o,
  output logic             s_o,
  output logic             z_we_o,
  output logic             c_we_o,
  output logic             n_we_o,
  output logic             v_we_o,
  output logic             s_we_o
);
  logic [WIDTH-1:0] res_d, res_q;
  logic             cy_d, flag_op;
  shrot_flags_t     flg_d, flg_q, we_d, we_q;

  shrot_datapath #(.WIDTH(WIDTH)) u_dp (
    .op_i      (shrot_op_e'(op_i)),
    .operand_i (operand_i),
    .carry_i   (carry_i),
    .result_o  (res_d),
    .carry_o   (cy_d),
    .flag_op_o (flag_op)
  );

  shrot_flag_gen #(.WIDTH(WIDTH)) u_flg (
    .result_i  (res_d),
    .carry_i   (cy_d),
    .flag_op_i (flag_op),
    .flags_o   (flg_d),
    .we_o      (we_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      flg_q <= '0;
      we_q  <= '0;
    end else begin
      res_q <= res_d;
      flg_q <= flg_d;
      we_q  <= we_d;
    end
  end

  assign result_o = res_q;
  assign z_o      = flg_q.z;
  assign c_o      = flg_q.c;
  assign n_o      = flg_q.n;
  assign v_o      = flg_q.v;
  assign s_o      = flg_q.s;
  assign z_we_o   = we_q.z;
  assign c_we_o   = we_q.c;
  assign n_we_o   = we_q.n;
  assign v_we_o   = we_q.v;
  assign s_we_o   = we_q.s;
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] operand_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             z_o,
  input logic             c_o,
  input logic             n_o,
  input logic             v_o,
  input logic             s_o,
  input logic             z_we_o,
  input logic             c_we_o,
  input logic             n_we_o,
  input logic             v_we_o,
  input logic             s_we_o
);
  localparam int unsigned HALF = WIDTH / 2;

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (result_o == '0 && !z_we_o && !c_we_o && !c_o && !z_o)); // R1

  AST_SHL_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(op_i) == 3'd0) |->
      (result_o[0] == 1'b0 && c_o == $past(operand_i[WIDTH-1]))); // R2

  AST_SHR_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(op_i) == 3'd1) |->
      (result_o[WIDTH-1] == 1'b0 && c_o == $past(operand_i[0]))); // R3

  AST_ROTL_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(op_i) == 3'd2) |->
      (result_o[0] == $past(carry_i) && c_o == $past(operand_i[WIDTH-1]))); // R4

  AST_ROTR_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(op_i) == 3'd3) |->
      (result_o[WIDTH-1] == $past(carry_i) && c_o == $past(operand_i[0]))); // R5

  AST_SAR_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(op_i) == 3'd4) |->
      (result_o[WIDTH-1] == $past(operand_i[WIDTH-1]))); // R6

  AST_SWAP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(op_i) == 3'd5) |->
      ($countones({z_we_o, c_we_o, n_we_o, v_we_o, s_we_o}) == 0 &&
       result_o == {$past(operand_i[HALF-1:0]), $past(operand_i[WIDTH-1:HALF])})); // R7

  AST_N_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_we_o |-> (n_o == result_o[WIDTH-1])); // R8

  AST_V_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_we_o |-> (v_o == (n_o ^ c_o))); // R8

  AST_S_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_we_o |-> (s_o == (n_o ^ v_o))); // R8

  AST_Z_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_we_o |-> (z_o == (result_o == '0))); // R8

  AST_RSV_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(op_i) >= 3'd6) |->
      (result_o == $past(operand_i) && !z_we_o && !c_we_o && !n_we_o)); // R10
endmodule

bind shrot_unit shrot_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;
  localparam int unsigned WIDTH  = 8;
  localparam time         CLK_PD = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       op = '0;
  logic [WIDTH-1:0] opnd = '0;
  logic             cin = 1'b0;
  logic [WIDTH-1:0] result;
  logic             z, c, n, v, s, z_we, c_we, n_we, v_we, s_we;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PD/2) clk = ~clk;

  shrot_unit #(.WIDTH(WIDTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .operand_i(opnd), .carry_i(cin),
    .result_o(result), .z_o(z), .c_o(c), .n_o(n), .v_o(v), .s_o(s),
    .z_we_o(z_we), .c_we_o(c_we), .n_we_o(n_we), .v_we_o(v_we), .s_we_o(s_we)
  );

  // packed view: result, flags zcnvs, strobes zcnvs
  function automatic logic [WIDTH+9:0] observed();
    return {result, z, c, n, v, s, z_we, c_we, n_we, v_we, s_we};
  endfunction

  function automatic logic [WIDTH+9:0] expect_of(logic [2:0] o, logic [WIDTH-1:0] a, logic ci);
    logic [WIDTH-1:0] r;
    logic co, fz, fn, fv, fs, wr;
    co = 1'b0;
    wr = 1'b1;
    case (o)
      3'd0: begin r = {a[WIDTH-2:0], 1'b0}; co = a[WIDTH-1]; end
      3'd1: begin r = {1'b0, a[WIDTH-1:1]}; co = a[0]; end
      3'd2: begin r = {a[WIDTH-2:0], ci};   co = a[WIDTH-1]; end
      3'd3: begin r = {ci, a[WIDTH-1:1]};   co = a[0]; end
      3'd4: begin r = {a[WIDTH-1], a[WIDTH-1:1]}; co = a[0]; end
      3'd5: begin r = {a[WIDTH/2-1:0], a[WIDTH-1:WIDTH/2]}; wr = 1'b0; end
      default: begin r = a; wr = 1'b0; end
    endcase
    fn = r[WIDTH-1];
    fz = (r == '0);
    fv = fn ^ co;
    fs = fn ^ fv;
    if (!wr) return {r, 10'b0};
    return {r, fz, co, fn, fv, fs, 5'b11111};
  endfunction

  task automatic check(string tag, logic [WIDTH+9:0] act, logic [WIDTH+9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample after the next rising edge
  task automatic run(string tag, logic [2:0] o, logic [WIDTH-1:0] a, logic ci);
    @(negedge clk);
    op = o; opnd = a; cin = ci;
    @(posedge clk);
    #1;
    check(tag, observed(), expect_of(o, a, ci));
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op = 3'd2; opnd = 8'hFF; cin = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset", observed(), '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_shl();
    run("R2 shl 0xA5", 3'd0, 8'hA5, 1'b1);
    run("R2 shl 0x40", 3'd0, 8'h40, 1'b0);
  endtask

  task automatic t_shr();
    run("R3 shr 0x81", 3'd1, 8'h81, 1'b1);
    run("R3 shr 0x01 zero", 3'd1, 8'h01, 1'b0);
  endtask

  task automatic t_rotl();
    run("R4 rotl carry in", 3'd2, 8'h3C, 1'b1);
    run("R4 rotl 0x80 to zero", 3'd2, 8'h80, 1'b0);
  endtask

  task automatic t_rotr();
    run("R5 rotr carry in", 3'd3, 8'h02, 1'b1);
    run("R5 rotr 0x01 to zero", 3'd3, 8'h01, 1'b0);
  endtask

  task automatic t_sar();
    run("R6 sar negative", 3'd4, 8'h85, 1'b0);
    run("R6 sar positive", 3'd4, 8'h7E, 1'b1);
  endtask

  task automatic t_swap();
    run("R7 swap 0x3C", 3'd5, 8'h3C, 1'b1);
    run("R7 swap 0x00", 3'd5, 8'h00, 1'b1);
  endtask

  task automatic t_flags();
    // zero and carry together on a rotate, then a sign case
    run("R8 rotl zero+carry", 3'd2, 8'h80, 1'b0);
    run("R8 shl negative", 3'd0, 8'h40, 1'b0);
    for (int i = 0; i < 5; i++) begin
      run("R8 sweep", 3'(i), 8'(8'h11 * i + 8'h0F), 1'(i & 1));
    end
  endtask

  task automatic t_pipeline();
    // consecutive ops, each result one cycle after its inputs
    logic [2:0]       o_seq [4] = '{3'd5, 3'd0, 3'd5, 3'd4};
    logic [WIDTH-1:0] a_seq [4] = '{8'hF0, 8'hFF, 8'h12, 8'h80};
    for (int i = 0; i < 4; i++) begin
      run("R9 back to back", o_seq[i], a_seq[i], 1'b1);
    end
    @(negedge clk);
    op = 3'd1; opnd = 8'hAA; cin = 1'b0;
    #1;
    check("R9 no early change", observed(), expect_of(3'd4, 8'h80, 1'b1));
  endtask

  task automatic t_reserved();
    run("R10 code 6", 3'd6, 8'hC3, 1'b1);
    run("R10 code 7", 3'd7, 8'h00, 1'b0);
  endtask

  initial begin
    t_reset();
    t_shl();
    t_shr();
    t_rotl();
    t_rotr();
    t_sar();
    t_swap();
    t_flags();
    t_pipeline();
    t_reserved();
    t_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule